// File: doc/BRIEF.md
# Distributed Global Time Base

This block keeps one node's local view of cluster-wide time as three nested counters. A microtick counter runs on the local oscillator and rolls over at a configured terminal count. Each rollover advances a macrotick counter, and each macrotick rollover advances a cycle (round) counter. The pair cycle:macrotick is the global time that the host reads and that the TDMA scheduler follows. Slot and round boundary strobes are derived from the macrotick position.

No node acts as master. When the receive path sees the start of any frame, it raises a read strobe and supplies the macrotick at which that frame's slot was due to begin. The block compares its own time at that instant with the expected instant plus the configured bus propagation delay. The signed offset is clamped and held. It is then applied once, at the next microtick rollover, by lengthening or shortening the following macrotick. An offset too large to be credible is rejected and flagged. A startup controller can overwrite the whole time state through a load port.

Top module: `global_time_base`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `time_mt`, `time_cyc` and `slot_idx` read 0, and `slot_start`, `round_start` and `sync_err` read 0.
- R2: Without a correction, every macrotick lasts `cfg_ut_max`+1 clock cycles.
- R3: `time_mt` steps by one from 0 up to `cfg_mt_max` and then returns to 0. On that return `time_cyc` increments, and after `cfg_cyc_max` it returns to 0.
- R4: On a cycle with `sof_strobe` high, the block forms D = (`time_mt` − `sof_expected_mt`)·(`cfg_ut_max`+1) + microtick − `cfg_prop_delay` from its state in that cycle. Here microtick is the count since the current macrotick began, with 0 at the start. At the next microtick rollover, a positive D makes the following macrotick D cycles longer and a negative D makes it |D| cycles shorter.
- R5: A correction is applied to exactly one macrotick. Later macroticks return to the nominal length.
- R6: The applied correction is limited to the range −`cfg_corr_max` to +`cfg_corr_max`.
- R7: If |D| > `cfg_err_thr`, `sync_err` is high for the single cycle after the strobe and no correction is applied.
- R8: With `ld_en` high, the next cycle shows `ld_cyc`, `ld_mt` and microtick `ld_ut`. Any pending correction is discarded, and a strobe in the same cycle is ignored.
- R9: `slot_start` pulses for one cycle whenever `time_mt` enters a multiple of `cfg_mt_per_slot`. In that cycle `slot_idx` shows the slot number (`time_mt` / `cfg_mt_per_slot`). The pulse does not occur at other macroticks.
- R10: `round_start` pulses for one cycle exactly when `time_mt` returns to 0, together with `slot_start` and `slot_idx` = 0.
- R11: A second strobe before the rollover replaces the pending correction, so only the latest offset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock, one microtick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ut_max | input | 8 | Microtick terminal count (macrotick length minus one) |
| cfg_mt_max | input | 10 | Last macrotick of a round |
| cfg_cyc_max | input | 4 | Last cycle value before wrap |
| cfg_mt_per_slot | input | 10 | Macroticks per TDMA slot, at least 1 |
| cfg_prop_delay | input | 8 | Bus propagation delay in microticks |
| cfg_corr_max | input | 8 | Largest correction magnitude applied |
| cfg_err_thr | input | 18 | Offset magnitude above which a reading is rejected |
| sof_strobe | input | 1 | Clock-read request at a received start of frame |
| sof_expected_mt | input | 10 | Macrotick at which the received frame's slot was due |
| ld_en | input | 1 | Load the time state from the ld_* inputs |
| ld_cyc | input | 4 | Cycle value to load |
| ld_mt | input | 10 | Macrotick value to load |
| ld_ut | input | 8 | Microtick value to load |
| time_mt | output | 10 | Current macrotick |
| time_cyc | output | 4 | Current cycle |
| slot_idx | output | 5 | Current slot number within the round |
| slot_start | output | 1 | One-cycle pulse at each slot boundary |
| round_start | output | 1 | One-cycle pulse at each round boundary |
| sync_err | output | 1 | One-cycle pulse when a reading is rejected |

## Verification
The assertions assume a stable configuration. They also assume `cfg_mt_per_slot` is at least 1, `cfg_corr_max` does not exceed `cfg_ut_max`, and loaded values lie inside their configured limits. Every frame's expected macrotick is assumed to fall in the same round as the reading. The bench sets the configuration once, before reset ends, and does not change it. Loads are always in range. Each strobe is placed a known number of cycles after a load, and its expected macrotick is the loaded macrotick or one next to it, so every offset has a known value.

// File: rtl/gtb_pkg.sv
package gtb_pkg;
    localparam int UT_W   = 8;               // microtick counter width
    localparam int MT_W   = 10;              // macrotick counter width
    localparam int CYC_W  = 4;               // cycle counter width
    localparam int SLOT_W = 5;               // slot index width
    localparam int THR_W  = UT_W + MT_W;     // error threshold width
    localparam int COR_W  = UT_W + 1;        // signed correction width
    localparam int UTS_W  = UT_W + 2;        // signed running microtick width
    localparam int DIF_W  = MT_W + UT_W + 3; // signed offset width

    typedef logic [UT_W-1:0]          ut_t;
    typedef logic [MT_W-1:0]          mt_t;
    typedef logic [CYC_W-1:0]         cyc_t;
    typedef logic [SLOT_W-1:0]        slot_t;
    typedef logic [THR_W-1:0]         thr_t;
    typedef logic signed [COR_W-1:0]  cor_t;
    typedef logic signed [UTS_W-1:0]  uts_t;
    typedef logic signed [DIF_W-1:0]  dif_t;

    // result of one clock reading
    typedef struct packed {
        logic valid;   // correction accepted
        logic err;     // reading rejected
        cor_t corr;    // clamped correction
    } meas_t;

    function automatic cor_t clamp_corr(dif_t d, ut_t lim);
        dif_t l;
        l = dif_t'({1'b0, lim});
        if (d > l)
            return cor_t'(l);
        else if (d < -l)
            return cor_t'(-l);
        else
            return cor_t'(d);
    endfunction

    function automatic dif_t abs_dif(dif_t d);
        return (d < 0) ? -d : d;
    endfunction
endpackage

// File: rtl/gtb_offset.sv
module gtb_offset
    import gtb_pkg::*;
(
    input  logic  strobe,
    input  mt_t   cur_mt,
    input  uts_t  cur_ut,
    input  mt_t   exp_mt,
    input  ut_t   cfg_ut_max,
    input  ut_t   cfg_prop_delay,
    input  ut_t   cfg_corr_max,
    input  thr_t  cfg_err_thr,
    output meas_t meas
);
    dif_t mt_delta;
    dif_t mt_len;
    dif_t raw;
    logic too_far;

    always_comb begin
        mt_delta = dif_t'($signed({1'b0, cur_mt})) - dif_t'($signed({1'b0, exp_mt}));
        mt_len   = dif_t'({1'b0, cfg_ut_max}) + dif_t'(1);
        raw      = mt_delta * mt_len + dif_t'(cur_ut) - dif_t'({1'b0, cfg_prop_delay});
        too_far  = abs_dif(raw) > dif_t'({1'b0, cfg_err_thr});
        meas.valid = strobe && !too_far;
        meas.err   = strobe && too_far;
        meas.corr  = clamp_corr(raw, cfg_corr_max);
    end
endmodule

// File: rtl/gtb_tick.sv
module gtb_tick
    import gtb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_en,
    input  ut_t   ld_ut,
    input  ut_t   cfg_ut_max,
    input  meas_t meas,
    output uts_t  ut,
    output logic  wrap
);
    uts_t ut_q;
    cor_t pend_q;

    assign wrap = (ut_q == uts_t'({1'b0, cfg_ut_max}));
    assign ut   = ut_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ut_q   <= '0;
            pend_q <= '0;
        end else if (ld_en) begin
            ut_q   <= uts_t'({1'b0, ld_ut});
            pend_q <= '0;
        end else begin
            // restarting below zero stretches, above zero shortens
            ut_q <= wrap ? -uts_t'(pend_q) : ut_q + uts_t'(1);
            if (meas.valid)
                pend_q <= meas.corr;
            else if (wrap)
                pend_q <= '0;
        end
    end
endmodule

// File: rtl/gtb_horizon.sv
module gtb_horizon
    import gtb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wrap,
    input  logic  ld_en,
    input  mt_t   ld_mt,
    input  cyc_t  ld_cyc,
    input  mt_t   cfg_mt_max,
    input  cyc_t  cfg_cyc_max,
    input  mt_t   cfg_mt_per_slot,
    output mt_t   mt,
    output cyc_t  cyc,
    output slot_t slot_idx,
    output logic  slot_start,
    output logic  round_start
);
    mt_t   mt_q, spos_q;
    cyc_t  cyc_q;
    slot_t sidx_q;
    logic  slot_p, round_p;
    logic  end_round, end_slot;

    assign end_round = (mt_q == cfg_mt_max);
    assign end_slot  = (spos_q == cfg_mt_per_slot - mt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mt_q    <= '0;
            cyc_q   <= '0;
            spos_q  <= '0;
            sidx_q  <= '0;
            slot_p  <= 1'b0;
            round_p <= 1'b0;
        end else if (ld_en) begin
            mt_q    <= ld_mt;
            cyc_q   <= ld_cyc;
            spos_q  <= ld_mt % cfg_mt_per_slot;
            sidx_q  <= slot_t'(ld_mt / cfg_mt_per_slot);
            slot_p  <= 1'b0;
            round_p <= 1'b0;
        end else if (wrap) begin
            if (end_round) begin
                mt_q    <= '0;
                cyc_q   <= (cyc_q == cfg_cyc_max) ? '0 : cyc_q + cyc_t'(1);
                spos_q  <= '0;
                sidx_q  <= '0;
                slot_p  <= 1'b1;
                round_p <= 1'b1;
            end else if (end_slot) begin
                mt_q    <= mt_q + mt_t'(1);
                spos_q  <= '0;
                sidx_q  <= sidx_q + slot_t'(1);
                slot_p  <= 1'b1;
                round_p <= 1'b0;
            end else begin
                mt_q    <= mt_q + mt_t'(1);
                spos_q  <= spos_q + mt_t'(1);
                slot_p  <= 1'b0;
                round_p <= 1'b0;
            end
        end else begin
            slot_p  <= 1'b0;
            round_p <= 1'b0;
        end
    end

    assign mt          = mt_q;
    assign cyc         = cyc_q;
    assign slot_idx    = sidx_q;
    assign slot_start  = slot_p;
    assign round_start = round_p;
endmodule

// File: rtl/global_time_base.sv
module global_time_base
    import gtb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [UT_W-1:0]     cfg_ut_max,
    input  logic [MT_W-1:0]     cfg_mt_max,
    input  logic [CYC_W-1:0]    cfg_cyc_max,
    input  logic [MT_W-1:0]     cfg_mt_per_slot,
    input  logic [UT_W-1:0]     cfg_prop_delay,
    input  logic [UT_W-1:0]     cfg_corr_max,
    input  logic [THR_W-1:0]    cfg_err_thr,
    input  logic                sof_strobe,
    input  logic [MT_W-1:0]     sof_expected_mt,
    input  logic                ld_en,
    input  logic [CYC_W-1:0]    ld_cyc,
    input  logic [MT_W-1:0]     ld_mt,
    input  logic [UT_W-1:0]     ld_ut,
    output logic [MT_W-1:0]     time_mt,
    output logic [CYC_W-1:0]    time_cyc,
    output logic [SLOT_W-1:0]   slot_idx,
    output logic                slot_start,
    output logic                round_start,
    output logic                sync_err
);
    uts_t  ut_now;
    logic  wrap;
    meas_t meas;
    logic  err_q;

    gtb_offset u_offset (
        .strobe         (sof_strobe),
        .cur_mt         (time_mt),
        .cur_ut         (ut_now),
        .exp_mt         (sof_expected_mt),
        .cfg_ut_max     (cfg_ut_max),
        .cfg_prop_delay (cfg_prop_delay),
        .cfg_corr_max   (cfg_corr_max),
        .cfg_err_thr    (cfg_err_thr),
        .meas           (meas)
    );

    gtb_tick u_tick (
        .clk        (clk),
        .rst        (rst),
        .ld_en      (ld_en),
        .ld_ut      (ld_ut),
        .cfg_ut_max (cfg_ut_max),
        .meas       (meas),
        .ut         (ut_now),
        .wrap       (wrap)
    );

    gtb_horizon u_horizon (
        .clk             (clk),
        .rst             (rst),
        .wrap            (wrap),
        .ld_en           (ld_en),
        .ld_mt           (ld_mt),
        .ld_cyc          (ld_cyc),
        .cfg_mt_max      (cfg_mt_max),
        .cfg_cyc_max     (cfg_cyc_max),
        .cfg_mt_per_slot (cfg_mt_per_slot),
        .mt              (time_mt),
        .cyc             (time_cyc),
        .slot_idx        (slot_idx),
        .slot_start      (slot_start),
        .round_start     (round_start)
    );

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else
            err_q <= meas.err && !ld_en;
    end

    assign sync_err = err_q;
endmodule

// File: rtl/global_time_base_chk.sv
module global_time_base_chk
    import gtb_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  sof_strobe,
    input logic  ld_en,
    input mt_t   ld_mt,
    input cyc_t  ld_cyc,
    input mt_t   time_mt,
    input cyc_t  time_cyc,
    input slot_t slot_idx,
    input logic  slot_start,
    input logic  round_start,
    input logic  sync_err
);
    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (time_mt == '0 && time_cyc == '0 && !slot_start && !round_start && !sync_err));

    // R3
    p_mt_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(ld_en) && !$stable(time_mt)) |-> (time_mt == $past(time_mt) + mt_t'(1) || time_mt == '0));

    // R3
    p_cyc_at_round_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(ld_en) && !$stable(time_cyc)) |-> (time_mt == '0));

    // R7
    p_err_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> ($past(sof_strobe) && !$past(ld_en)));

    // R8
    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (time_mt == $past(ld_mt) && time_cyc == $past(ld_cyc)));

    // R9
    p_slot_on_step_r9: assert property (@(posedge clk) disable iff (rst)
        slot_start |-> (!$past(ld_en) && !$stable(time_mt)));

    // R10
    p_round_with_slot0_r10: assert property (@(posedge clk) disable iff (rst)
        round_start |-> (slot_start && slot_idx == '0 && time_mt == '0));
endmodule

bind global_time_base global_time_base_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sof_strobe  (sof_strobe),
    .ld_en       (ld_en),
    .ld_mt       (ld_mt),
    .ld_cyc      (ld_cyc),
    .time_mt     (time_mt),
    .time_cyc    (time_cyc),
    .slot_idx    (slot_idx),
    .slot_start  (slot_start),
    .round_start (round_start),
    .sync_err    (sync_err)
);

// File: tb/global_time_base_tb.sv
module global_time_base_tb;
    import gtb_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    ut_t   cfg_ut_max      = ut_t'(9);
    mt_t   cfg_mt_max      = mt_t'(39);
    cyc_t  cfg_cyc_max     = cyc_t'(3);
    mt_t   cfg_mt_per_slot = mt_t'(8);
    ut_t   cfg_prop_delay  = ut_t'(1);
    ut_t   cfg_corr_max    = ut_t'(5);
    thr_t  cfg_err_thr     = thr_t'(40);
    logic  sof_strobe      = 1'b0;
    mt_t   sof_expected_mt = '0;
    logic  ld_en           = 1'b0;
    cyc_t  ld_cyc          = '0;
    mt_t   ld_mt           = '0;
    ut_t   ld_ut           = '0;
    mt_t   time_mt;
    cyc_t  time_cyc;
    slot_t slot_idx;
    logic  slot_start, round_start, sync_err;

    int n_checks = 0;
    int n_fails  = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    global_time_base u_dut (
        .clk(clk), .rst(rst),
        .cfg_ut_max(cfg_ut_max), .cfg_mt_max(cfg_mt_max), .cfg_cyc_max(cfg_cyc_max),
        .cfg_mt_per_slot(cfg_mt_per_slot), .cfg_prop_delay(cfg_prop_delay),
        .cfg_corr_max(cfg_corr_max), .cfg_err_thr(cfg_err_thr),
        .sof_strobe(sof_strobe), .sof_expected_mt(sof_expected_mt),
        .ld_en(ld_en), .ld_cyc(ld_cyc), .ld_mt(ld_mt), .ld_ut(ld_ut),
        .time_mt(time_mt), .time_cyc(time_cyc), .slot_idx(slot_idx),
        .slot_start(slot_start), .round_start(round_start), .sync_err(sync_err)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // load at the next edge; returns at the negedge just after it
    task automatic do_load(input int c, input int m, input int u);
        @(negedge clk);
        ld_en = 1'b1; ld_cyc = cyc_t'(c); ld_mt = mt_t'(m); ld_ut = ut_t'(u);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // strobe while the microtick equals ut_pos (counted from a load with ut=0)
    task automatic strobe_at(input int ut_pos, input int exp_mt);
        repeat (ut_pos) @(negedge clk);
        sof_strobe = 1'b1; sof_expected_mt = mt_t'(exp_mt);
        @(negedge clk);
        sof_strobe = 1'b0;
    endtask

    task automatic mt_len(input int target, output int n);
        while (int'(time_mt) != target) @(negedge clk);
        n = 0;
        while (int'(time_mt) == target) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(int'(time_mt), 0, "R1 mt in reset");
        check(int'(time_cyc), 0, "R1 cyc in reset");
        check(int'(slot_idx), 0, "R1 slot in reset");
        check(int'(slot_start) + int'(round_start) + int'(sync_err), 0, "R1 pulses in reset");
        rst = 1'b0;
        @(negedge clk);
        check(int'(time_mt), 0, "R1 mt after reset");
        check(int'(sync_err), 0, "R1 err after reset");
    endtask

    task automatic t_nominal;
        int n;
        mt_len(2, n);
        check(n, 10, "R2 nominal macrotick length");
        mt_len(3, n);
        check(n, 10, "R2 second macrotick length");
    endtask

    task automatic t_stretch;
        int n;
        do_load(1, 20, 0);
        strobe_at(4, 20);              // D = 0 + 4 - 1 = +3
        check(int'(sync_err), 0, "R4 no error on small offset");
        mt_len(21, n);
        check(n, 13, "R4 positive offset stretches");
        mt_len(22, n);
        check(n, 10, "R5 next macrotick nominal");
    endtask

    task automatic t_shrink;
        int n;
        do_load(1, 20, 0);
        strobe_at(7, 21);              // D = -10 + 7 - 1 = -4
        mt_len(21, n);
        check(n, 6, "R4 negative offset shortens");
        mt_len(22, n);
        check(n, 10, "R5 after shortening nominal");
    endtask

    task automatic t_clamp;
        int n;
        do_load(1, 20, 0);
        strobe_at(4, 19);              // D = +13 -> +5
        mt_len(21, n);
        check(n, 15, "R6 positive clamp");
        do_load(1, 20, 0);
        strobe_at(4, 22);              // D = -17 -> -5
        mt_len(21, n);
        check(n, 5, "R6 negative clamp");
    endtask

    task automatic t_error;
        int n;
        do_load(1, 20, 0);
        strobe_at(4, 25);              // D = -47, beyond 40
        check(int'(sync_err), 1, "R7 error pulse");
        @(negedge clk);
        check(int'(sync_err), 0, "R7 error pulse one cycle");
        mt_len(21, n);
        check(n, 10, "R7 rejected offset not applied");
    endtask

    task automatic t_replace;
        int n;
        do_load(1, 20, 0);
        strobe_at(4, 20);              // +3 pending
        strobe_at(2, 21);              // at ut 7: -4 replaces it
        mt_len(21, n);
        check(n, 6, "R11 latest offset wins");
    endtask

    task automatic t_load_priority;
        int n;
        do_load(1, 20, 0);
        strobe_at(4, 20);              // +3 pending
        @(negedge clk);
        ld_en = 1'b1; ld_cyc = cyc_t'(2); ld_mt = mt_t'(30); ld_ut = ut_t'(0);
        sof_strobe = 1'b1; sof_expected_mt = mt_t'(10);
        @(negedge clk);
        ld_en = 1'b0; sof_strobe = 1'b0;
        check(int'(time_mt), 30, "R8 loaded macrotick");
        check(int'(time_cyc), 2, "R8 loaded cycle");
        check(int'(sync_err), 0, "R8 strobe ignored during load");
        check(int'(slot_idx), 3, "R9 slot realigned on load");
        mt_len(31, n);
        check(n, 10, "R8 pending correction discarded");
        do_load(0, 5, 6);
        mt_len(5, n);
        check(n, 4, "R8 loaded microtick");
    endtask

    task automatic t_round;
        do_load(3, 38, 0);
        while (time_mt != '0) @(negedge clk);
        check(int'(time_cyc), 0, "R3 cycle wraps to 0");
        check(int'(round_start), 1, "R10 round pulse");
        check(int'(slot_start), 1, "R10 slot pulse at round");
        check(int'(slot_idx), 0, "R10 slot index 0");
        @(negedge clk);
        check(int'(round_start), 0, "R10 round pulse one cycle");
        while (time_mt != mt_t'(1)) @(negedge clk);
        check(int'(slot_start), 0, "R9 no pulse inside slot");
        while (time_mt != mt_t'(8)) @(negedge clk);
        check(int'(slot_start), 1, "R9 pulse at slot boundary");
        check(int'(slot_idx), 1, "R9 slot index");
        while (time_mt != mt_t'(39)) @(negedge clk);
        check(int'(slot_idx), 4, "R9 last slot index");
        while (time_mt != '0) @(negedge clk);
        check(int'(time_cyc), 1, "R3 cycle increments");
    endtask

    initial begin
        t_reset();
        t_nominal();
        t_stretch();
        t_shrink();
        t_clamp();
        t_error();
        t_replace();
        t_load_priority();
        t_round();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule